// File: doc/BRIEF.md
# Pad Compensation Cell Controller

This block sits between a register bus and an analog pad-compensation cell. Software turns the cell on and off through two write-one aliases, one that sets the enable and one that clears it. After enabling, the controller waits a programmable settling time and for the cell's own ready indication before it reports the cell as ready.

While the cell runs in automatic mode, the controller keeps a copy of the pull-up and pull-down codes the cell measures and passes that copy to the pads. Software can read that copy, write the values into the two override fields and set the software-control bit. The pads then see the frozen override codes, and the captured copy stops tracking the cell.

The controller is a three-state machine. `ST_OFF` means the cell is disabled. `ST_SETTLE` means the cell is enabled and the controller is counting the settling time or waiting for the cell. `ST_READY` means the cell is enabled and its codes are valid. The transitions are:
- `enable` goes from `ST_OFF` to `ST_SETTLE`.
- `settled` goes from `ST_SETTLE` to `ST_READY` once the count has expired and the cell reports ready.
- `lost` goes from `ST_READY` to `ST_SETTLE` when the cell drops its ready; the count starts again.
- `disable` goes from any state to `ST_OFF`.

Top module: `ioc_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `cell_en_o` is 0, both code outputs are 0 and `bus_rdata` reads 0 at offsets 0x0, 0x4 and 0x8.
- R2: A write to offset 0x4 with bit 0 set raises `cell_en_o` at the next clock edge. A write there with bit 0 clear changes nothing, and a repeated set while enabled changes nothing.
- R3: A write to offset 0x8 with bit 0 set drops `cell_en_o` and the ready flag at the next clock edge, from any state. A write there with bit 0 clear changes nothing.
- R4: Offsets 0x4 and 0x8 both read the current enable state in bit 0, and all their other bits read 0.
- R5: The ready flag (bit 8 of offset 0x0) is read-only. It rises at the first clock edge that is at least SETTLE_CYCLES edges after the enabling write edge and at which `cell_rdy_i` is high.
- R6: If `cell_rdy_i` is low at a clock edge while the ready flag is set, the flag clears at that edge and the full settling count starts again.
- R7: When bit 1 of offset 0x0 (software control) is 1, `code_pd_o` equals the override field in bits 19:16 and `code_pu_o` equals the override field in bits 23:20. Both fields and bit 1 are read/write.
- R8: When software control is 0, the code outputs equal the captured measured codes. While the flag is ready and software control is 0, these are loaded at each clock edge from `cell_pd_i` and `cell_pu_i`.
- R9: The captured pull-down code reads at bits 27:24 and the captured pull-up code at bits 31:28 of offset 0x0. They hold their value whenever the flag is not ready or software control is 1, and writes to those bits are ignored.
- R10: Bits 0, 7:2 and 15:9 of offset 0x0 read 0 whatever was written. A write to any offset other than 0x0, 0x4 or 0x8 changes no state, and such offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cell_en_o | output | 1 | Enable to the compensation cell |
| cell_rdy_i | input | 1 | Cell reports its measured codes valid |
| cell_pd_i | input | 4 | Measured pull-down code from the cell |
| cell_pu_i | input | 4 | Measured pull-up code from the cell |
| code_pd_o | output | 4 | Pull-down code applied to the pads |
| code_pu_o | output | 4 | Pull-up code applied to the pads |

## Verification
Every write takes effect at the clock edge that samples it. The enable and the register fields change at that edge. The ready flag follows SETTLE_CYCLES edges after the enabling edge, or at a later edge when the cell is slow. A captured code appears one edge after the cell presents it. The read data is combinational on the address, so it is valid in the same cycle. The bench drives every input 2 ns after the rising edge. At each edge it advances a behavioural reference from those inputs, and at the falling edge it compares all outputs and the read word with that reference, so each result is checked in the exact cycle it is due.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_READY  = 2'd2
    } ioc_state_e;

    localparam int CODE_W      = 4;
    localparam int DATA_W      = 32;

    // byte offsets of the three registers
    localparam int OFS_CTRL    = 0;
    localparam int OFS_EN_SET  = 4;
    localparam int OFS_EN_CLR  = 8;

    // control word field positions
    localparam int BIT_SWCTL   = 1;
    localparam int BIT_READY   = 8;
    localparam int LSB_OVR_PD  = 16;
    localparam int LSB_OVR_PU  = 20;
    localparam int LSB_MEAS_PD = 24;
    localparam int LSB_MEAS_PU = 28;

endpackage

// File: rtl/ioc_decode.sv
module ioc_decode
    import ioc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wdata_b0,
    output logic              wr_ctrl,
    output logic              en_set,
    output logic              en_clr,
    output logic              rd_ctrl,
    output logic              rd_en
);

    logic hit_ctrl;
    logic hit_set;
    logic hit_clr;

    always_comb begin
        hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
        hit_set  = (bus_addr == ADDR_W'(OFS_EN_SET));
        hit_clr  = (bus_addr == ADDR_W'(OFS_EN_CLR));
        wr_ctrl  = bus_wr && hit_ctrl;
        en_set   = bus_wr && hit_set && wdata_b0;
        en_clr   = bus_wr && hit_clr && wdata_b0;
        rd_ctrl  = hit_ctrl;
        rd_en    = hit_set || hit_clr;
    end

endmodule

// File: rtl/ioc_regs.sv
module ioc_regs
    import ioc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_swctl,
    input  logic [CODE_W-1:0] wr_ovr_pd,
    input  logic [CODE_W-1:0] wr_ovr_pu,
    output logic              sw_ctrl,
    output logic [CODE_W-1:0] ovr_pd,
    output logic [CODE_W-1:0] ovr_pu
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_ctrl <= 1'b0;
            ovr_pd  <= '0;
            ovr_pu  <= '0;
        end else if (wr_ctrl) begin
            sw_ctrl <= wr_swctl;
            ovr_pd  <= wr_ovr_pd;
            ovr_pu  <= wr_ovr_pu;
        end
    end

endmodule

// File: rtl/ioc_fsm.sv
module ioc_fsm
    import ioc_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic en_clr,
    input  logic cell_rdy_i,
    output logic cell_en,
    output logic ready
);

    localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

    ioc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: enable, settled, lost, disable
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (en_clr) begin
            state_d = ST_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (en_set) begin
                        state_d = ST_SETTLE;
                        cnt_d   = '0;
                    end
                end
                ST_SETTLE: begin
                    if (cnt_q >= CNT_LAST && cell_rdy_i) begin
                        state_d = ST_READY;
                    end else if (cnt_q < CNT_LAST) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_READY: begin
                    if (!cell_rdy_i) begin
                        state_d = ST_SETTLE;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        cell_en = 1'b0;
        ready   = 1'b0;
        unique case (state_q)
            ST_OFF:    ;
            ST_SETTLE: cell_en = 1'b1;
            ST_READY: begin
                cell_en = 1'b1;
                ready   = 1'b1;
            end
            default:   ;
        endcase
    end

endmodule

// File: rtl/ioc_codes.sv
module ioc_codes
    import ioc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              sw_ctrl,
    input  logic [CODE_W-1:0] cell_pd_i,
    input  logic [CODE_W-1:0] cell_pu_i,
    input  logic [CODE_W-1:0] ovr_pd,
    input  logic [CODE_W-1:0] ovr_pu,
    output logic [CODE_W-1:0] meas_pd,
    output logic [CODE_W-1:0] meas_pu,
    output logic [CODE_W-1:0] code_pd,
    output logic [CODE_W-1:0] code_pu
);

    logic track;

    always_comb track = ready && !sw_ctrl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meas_pd <= '0;
            meas_pu <= '0;
        end else if (track) begin
            meas_pd <= cell_pd_i;
            meas_pu <= cell_pu_i;
        end
    end

    always_comb begin
        code_pd = sw_ctrl ? ovr_pd : meas_pd;
        code_pu = sw_ctrl ? ovr_pu : meas_pu;
    end

endmodule

// File: rtl/ioc_ctrl.sv
module ioc_ctrl
    import ioc_pkg::*;
#(
    parameter int ADDR_W        = 4,
    parameter int SETTLE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cell_en_o,
    input  logic              cell_rdy_i,
    input  logic [3:0]        cell_pd_i,
    input  logic [3:0]        cell_pu_i,
    output logic [3:0]        code_pd_o,
    output logic [3:0]        code_pu_o
);

    logic              wr_ctrl, en_set, en_clr, rd_ctrl, rd_en;
    logic              sw_ctrl, ready;
    logic [CODE_W-1:0] ovr_pd, ovr_pu, meas_pd, meas_pu;
    logic [DATA_W-1:0] ctrl_word;
    logic              wdata_unused;

    always_comb wdata_unused = ^{bus_wdata[31:24], bus_wdata[15:2]};

    ioc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wdata_b0 (bus_wdata[0]),
        .wr_ctrl  (wr_ctrl),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .rd_ctrl  (rd_ctrl),
        .rd_en    (rd_en)
    );

    ioc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_swctl  (bus_wdata[BIT_SWCTL]),
        .wr_ovr_pd (bus_wdata[LSB_OVR_PD +: CODE_W]),
        .wr_ovr_pu (bus_wdata[LSB_OVR_PU +: CODE_W]),
        .sw_ctrl   (sw_ctrl),
        .ovr_pd    (ovr_pd),
        .ovr_pu    (ovr_pu)
    );

    ioc_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_set     (en_set),
        .en_clr     (en_clr),
        .cell_rdy_i (cell_rdy_i),
        .cell_en    (cell_en_o),
        .ready      (ready)
    );

    ioc_codes u_codes (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ready),
        .sw_ctrl   (sw_ctrl),
        .cell_pd_i (cell_pd_i),
        .cell_pu_i (cell_pu_i),
        .ovr_pd    (ovr_pd),
        .ovr_pu    (ovr_pu),
        .meas_pd   (meas_pd),
        .meas_pu   (meas_pu),
        .code_pd   (code_pd_o),
        .code_pu   (code_pu_o)
    );

    always_comb begin
        ctrl_word = '0;
        ctrl_word[BIT_SWCTL]               = sw_ctrl;
        ctrl_word[BIT_READY]               = ready;
        ctrl_word[LSB_OVR_PD +: CODE_W]    = ovr_pd;
        ctrl_word[LSB_OVR_PU +: CODE_W]    = ovr_pu;
        ctrl_word[LSB_MEAS_PD +: CODE_W]   = meas_pd;
        ctrl_word[LSB_MEAS_PU +: CODE_W]   = meas_pu;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_ctrl) begin
            bus_rdata = ctrl_word;
        end else if (rd_en) begin
            bus_rdata[0] = cell_en_o;
        end
    end

endmodule

// File: rtl/ioc_ctrl_chk.sv
module ioc_ctrl_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wdata_b0,
    input logic [31:0]       bus_rdata,
    input logic              cell_en_o,
    input logic              cell_rdy_i,
    input logic [3:0]        cell_pd_i,
    input logic [3:0]        cell_pu_i,
    input logic [3:0]        code_pd_o,
    input logic [3:0]        code_pu_o,
    input logic              ready,
    input logic              sw_ctrl,
    input logic [3:0]        ovr_pd,
    input logic [3:0]        ovr_pu,
    input logic [3:0]        meas_pd,
    input logic [3:0]        meas_pu
);

    logic set_req, clr_req;

    always_comb begin
        set_req = bus_wr && (bus_addr == ADDR_W'(4)) && wdata_b0;
        clr_req = bus_wr && (bus_addr == ADDR_W'(8)) && wdata_b0;
    end

    assert_set_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> cell_en_o);

    assert_clear_disables_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (!cell_en_o && !ready));

    assert_enable_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(4) || bus_addr == ADDR_W'(8)) |->
            (bus_rdata == {31'b0, cell_en_o}));

    assert_ready_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> cell_en_o);

    assert_ready_needs_cell_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(cell_rdy_i));

    assert_ready_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !cell_rdy_i) |=> !ready);

    assert_override_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ctrl |-> (code_pd_o == ovr_pd && code_pu_o == ovr_pu));

    assert_track_cell_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !sw_ctrl) |=> (meas_pd == $past(cell_pd_i) && meas_pu == $past(cell_pu_i)));

    assert_meas_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && !sw_ctrl) |=> ($stable(meas_pd) && $stable(meas_pu)));

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(0)) |->
            (bus_rdata[15:9] == 7'b0 && bus_rdata[7:2] == 6'b0 && !bus_rdata[0]));

endmodule

bind ioc_ctrl ioc_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wdata_b0   (bus_wdata[0]),
    .bus_rdata  (bus_rdata),
    .cell_en_o  (cell_en_o),
    .cell_rdy_i (cell_rdy_i),
    .cell_pd_i  (cell_pd_i),
    .cell_pu_i  (cell_pu_i),
    .code_pd_o  (code_pd_o),
    .code_pu_o  (code_pu_o),
    .ready      (ready),
    .sw_ctrl    (sw_ctrl),
    .ovr_pd     (ovr_pd),
    .ovr_pu     (ovr_pu),
    .meas_pd    (meas_pd),
    .meas_pu    (meas_pu)
);

// File: tb/ioc_ctrl_bench.sv
`timescale 1ns/1ps
module ioc_ctrl_bench;

    localparam int SETTLE = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        cell_en_o;
    logic        cell_rdy_i = 1'b0;
    logic [3:0]  cell_pd_i = 4'h0;
    logic [3:0]  cell_pu_i = 4'h0;
    logic [3:0]  code_pd_o, code_pu_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ioc_ctrl #(.ADDR_W(4), .SETTLE_CYCLES(SETTLE)) u_ioc_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cell_en_o(cell_en_o),
        .cell_rdy_i(cell_rdy_i), .cell_pd_i(cell_pd_i), .cell_pu_i(cell_pu_i),
        .code_pd_o(code_pd_o), .code_pu_o(code_pu_o)
    );

    // behavioural cell: ready after cell_lat cycles enabled, codes drift
    int cell_lat = 2;
    int cell_cnt = 0;
    bit glitch = 0;
    int cyc = 0;
    always @(posedge clk) begin
        #2;
        cyc = cyc + 1;
        if (!cell_en_o) begin
            cell_cnt = 0;
            cell_rdy_i = 1'b0;
        end else begin
            cell_cnt = cell_cnt + 1;
            cell_rdy_i = (cell_cnt >= cell_lat) && !glitch;
        end
        cell_pd_i = 4'(cyc);
        cell_pu_i = 4'(cyc * 3 + 5);
    end

    // reference model: 0 off, 1 settling, 2 ready
    int m_state, m_cnt, m_sw, m_opd, m_opu, m_mpd, m_mpu;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_sw = 0;
            m_opd = 0; m_opu = 0; m_mpd = 0; m_mpu = 0;
        end else begin
            int ns;
            int nc;
            ns = m_state;
            nc = m_cnt;
            if (m_state == 2 && m_sw == 0) begin
                m_mpd = int'(cell_pd_i);
                m_mpu = int'(cell_pu_i);
            end
            if (bus_wr && bus_addr == 4'h8 && bus_wdata[0]) begin
                ns = 0; nc = 0;
            end else if (m_state == 0) begin
                if (bus_wr && bus_addr == 4'h4 && bus_wdata[0]) begin
                    ns = 1; nc = 0;
                end
            end else if (m_state == 1) begin
                if (m_cnt >= SETTLE - 1 && cell_rdy_i) ns = 2;
                else if (m_cnt < SETTLE - 1) nc = m_cnt + 1;
            end else begin
                if (!cell_rdy_i) begin
                    ns = 1; nc = 0;
                end
            end
            if (bus_wr && bus_addr == 4'h0) begin
                m_sw  = int'(bus_wdata[1]);
                m_opd = int'(bus_wdata[19:16]);
                m_opu = int'(bus_wdata[23:20]);
            end
            m_state = ns;
            m_cnt = nc;
        end
    end

    function automatic logic [31:0] model_read(input logic [3:0] a);
        logic [31:0] v;
        v = '0;
        if (a == 4'h0) begin
            v[1]     = (m_sw != 0);
            v[8]     = (m_state == 2);
            v[19:16] = 4'(m_opd);
            v[23:20] = 4'(m_opu);
            v[27:24] = 4'(m_mpd);
            v[31:28] = 4'(m_mpu);
        end else if (a == 4'h4 || a == 4'h8) begin
            v[0] = (m_state != 0);
        end
        return v;
    endfunction

    task automatic ck(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            ck({31'b0, cell_en_o}, {31'b0, m_state != 0}, "R2 R3 enable output");
            ck({28'b0, code_pd_o}, 32'(m_sw != 0 ? m_opd : m_mpd), "R7 R8 pull-down code");
            ck({28'b0, code_pu_o}, 32'(m_sw != 0 ? m_opu : m_mpu), "R7 R8 pull-up code");
            if (bus_addr == 4'h0)
                ck(bus_rdata, model_read(bus_addr), "R5 R6 R9 R10 control word");
            else if (bus_addr == 4'h4 || bus_addr == 4'h8)
                ck(bus_rdata, model_read(bus_addr), "R4 enable readback");
            else
                ck(bus_rdata, 32'h0, "R10 unmapped read");
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            bus_addr = 4'((i % 4) * 4);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state at the ports
        #1;
        ck({31'b0, cell_en_o}, 32'h0, "R1 enable in reset");
        ck({24'b0, code_pu_o, code_pd_o}, 32'h0, "R1 codes in reset");
        for (int k = 0; k < 3; k++) begin
            bus_addr = 4'(k * 4); #1;
            ck(bus_rdata, 32'h0, "R1 register in reset");
        end
        @(posedge clk); #2; rst_n = 1'b1;
        idle(2);
        // R10: reserved and read-only bits ignore writes
        wr(4'h0, 32'hFFFF_FFFF);
        idle(3);
        wr(4'h0, 32'h0);
        // R2: set with bit 0 clear does nothing
        wr(4'h4, 32'hFFFF_FFFE);
        idle(3);
        // R2 R5: fast cell, ready at the settling count
        cell_lat = 2;
        wr(4'h4, 32'h1);
        idle(SETTLE + 4);
        wr(4'h4, 32'h1);
        // R8 R9: automatic tracking
        idle(8);
        // R7 R9: frozen overrides
        wr(4'h0, 32'h00A5_0002);
        idle(6);
        wr(4'h0, 32'h003C_0000);
        idle(5);
        // R3: clear with bit 0 clear does nothing, then real clear
        wr(4'h8, 32'hFFFF_FFFE);
        idle(3);
        wr(4'h8, 32'h1);
        idle(4);
        // R5: slow cell, ready waits on the cell
        cell_lat = SETTLE + 5;
        wr(4'h4, 32'h1);
        idle(SETTLE + 10);
        // R6: cell drops ready for one cycle
        @(posedge clk); #2; glitch = 1;
        @(posedge clk); #2; glitch = 0;
        idle(SETTLE + 4);
        // R10: unmapped offset write ignored
        wr(4'hC, 32'hFFFF_FFFF);
        idle(4);
        // R3: clear while settling after enable
        wr(4'h8, 32'h1);
        wr(4'h4, 32'h1);
        idle(2);
        wr(4'h8, 32'h1);
        idle(4);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

endmodule